// File: doc/BRIEF.md
# Bidirectional Strobed Bus Port

This block is the handshake controller for an 8-bit peripheral port that sends and receives over the same set of pins. The CPU side writes outbound bytes into an output latch and reads inbound bytes from an input latch. The peripheral side works the other way round. It pulls an acknowledge line low to have the output latch driven onto the shared pins. It pulls a strobe line low to have the pin values captured into the input latch. The controller keeps the five handshake and status lines a host needs. These are an active-low output-full flag, an input-full flag, the strobe and acknowledge inputs, and one interrupt request that covers both directions.

The interrupt has two enables, one per direction. A bit set/reset decoder outside this block writes them through dedicated enable-write pulses. A configuration-load pulse returns the port to its idle handshake state. All peripheral inputs are taken as synchronous to `clk`. Reset is asserted asynchronously and released through a local synchronizer.

Top module: `bstrb_port`

## Requirements
- R1: While reset is held, and after it until the first stimulus, `obf_n` is 1, `ibf` is 0, `intr` is 0, `pa_out` is 0 and `cpu_rdata` is 0 when no read is selected.
- R2: A cycle with `cpu_wr_a` high stores `cpu_wdata` into the output latch and drives `obf_n` low from the next cycle. The latch is presented continuously on `pa_out`.
- R3: `pa_oe` is 1 exactly while `ack_n` is 0, in the same cycle, with no clock delay. Otherwise the pins are left undriven (`pa_oe` = 0).
- R4: `ack_n` sampled low returns `obf_n` high in the next cycle. If `cpu_wr_a` is high in that same cycle, the write wins and `obf_n` stays low.
- R5: Every cycle with `stb_n` sampled low loads `pa_in` into the input latch and sets `ibf` in the next cycle. The latch holds its value while `stb_n` is high.
- R6: While `cpu_rd_a` is high, `cpu_rdata` shows the input latch. At the end of a read, the first cycle `cpu_rd_a` is low after being high, `ibf` clears in the next cycle, unless `stb_n` is low in that cycle.
- R7: While `cpu_rd_st` is high it takes precedence over `cpu_rd_a`, and `cpu_rdata` shows the status byte: bit 7 = `obf_n` pin level, bit 6 = output enable, bit 5 = `ibf`, bit 4 = input enable, bit 3 = `intr`, bits 2..0 = 0.
- R8: `intr` = (output enable AND `obf_n` high) OR (input enable AND `ibf` high). A CPU write therefore withdraws the output cause, and a completed read withdraws the input cause.
- R9: `inte1_we` loads `inte_val` into the output-side enable, and `inte2_we` loads it into the input-side enable, from the next cycle. Both enables are 0 after reset.
- R10: `cfg_load` takes precedence over every other input in its cycle. From the next cycle, `obf_n` is 1, `ibf` is 0, both enables are 0 and the output latch is 0.
- R11: With neither `cpu_rd_a` nor `cpu_rd_st` high, `cpu_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Configuration-load pulse, returns the port to idle |
| inte1_we | input | 1 | Write pulse for the output-side interrupt enable |
| inte2_we | input | 1 | Write pulse for the input-side interrupt enable |
| inte_val | input | 1 | Value written by either enable pulse |
| cpu_wr_a | input | 1 | CPU write of the output latch |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd_a | input | 1 | CPU read of the input latch (level, held for the read) |
| cpu_rd_st | input | 1 | CPU read of the status byte |
| cpu_rdata | output | 8 | CPU read data |
| pa_in | input | 8 | Values seen on the shared pins |
| pa_out | output | 8 | Value to drive on the shared pins |
| pa_oe | output | 1 | Pin drive enable |
| stb_n | input | 1 | Peripheral strobe, active low |
| ibf | output | 1 | Input latch full |
| ack_n | input | 1 | Peripheral acknowledge, active low |
| obf_n | output | 1 | Output latch full, active low |
| intr | output | 1 | Combined interrupt request |

## Verification
The bench targets the same-cycle collisions. A write landing on an acknowledge must leave the new byte pending. A design that let the acknowledge win would drop an unsent byte. A strobe landing on the end of a read must keep `ibf` set. Getting that wrong loses fresh input data. The bench checks that the pin drive follows the acknowledge with no delay, because a registered enable would leave the pins undriven for the first acknowledged cycle. It also checks that the interrupt rises only for an enabled cause, falls on the withdrawing CPU access, and is cleared with everything else by a configuration load. Random traffic then mixes all inputs against a behavioural model.

// File: rtl/bstrb_pkg.sv
package bstrb_pkg;
  // Status byte bit positions; software decodes these.
  localparam int ST_OBF  = 7;
  localparam int ST_EN1  = 6;
  localparam int ST_IBF  = 5;
  localparam int ST_EN2  = 4;
  localparam int ST_INTR = 3;
  localparam int ST_W    = 8;

  typedef struct packed {
    logic en_out;
    logic en_in;
  } inte_t;
endpackage

// File: rtl/bstrb_rst_sync.sv
module bstrb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/bstrb_out_path.sv
module bstrb_out_path #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         ack_n,
  output logic [W-1:0] out_q,
  output logic         full_q
);
  logic [W-1:0] out_d;
  logic         full_d;
  logic         out_en;

  always_comb begin
    out_en = clr | wr;
    out_d  = clr ? '0 : wdata;
    full_d = full_q;
    if (clr)         full_d = 1'b0;
    else if (wr)     full_d = 1'b1;   // write beats a same-cycle acknowledge
    else if (!ack_n) full_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      full_q <= 1'b0;
    end else begin
      if (out_en) out_q <= out_d;
      full_q <= full_d;
    end
  end
endmodule

// File: rtl/bstrb_in_path.sv
module bstrb_in_path #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         stb_n,
  input  logic [W-1:0] pin,
  input  logic         rd,
  output logic [W-1:0] in_q,
  output logic         full_q
);
  logic rd_q;
  logic rd_end;
  logic cap_en;
  logic full_d;

  always_comb begin
    rd_end = rd_q & ~rd;
    cap_en = ~clr & ~stb_n;
    full_d = full_q;
    if (clr)         full_d = 1'b0;
    else if (!stb_n) full_d = 1'b1;   // strobe beats a same-cycle read end
    else if (rd_end) full_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q   <= '0;
      full_q <= 1'b0;
      rd_q   <= 1'b0;
    end else begin
      if (cap_en) in_q <= pin;
      full_q <= full_d;
      rd_q   <= rd;
    end
  end
endmodule

// File: rtl/bstrb_ctrl.sv
module bstrb_ctrl
  import bstrb_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            inte1_we,
  input  logic            inte2_we,
  input  logic            inte_val,
  input  logic            out_full,
  input  logic            in_full,
  output logic            irq,
  output logic [ST_W-1:0] status
);
  inte_t en_q;
  inte_t en_d;

  always_comb begin
    en_d = en_q;
    if (clr) begin
      en_d = '0;
    end else begin
      if (inte1_we) en_d.en_out = inte_val;
      if (inte2_we) en_d.en_in  = inte_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_d;
  end

  always_comb begin
    irq = (en_q.en_out & ~out_full) | (en_q.en_in & in_full);
    status          = '0;
    status[ST_OBF]  = ~out_full;
    status[ST_EN1]  = en_q.en_out;
    status[ST_IBF]  = in_full;
    status[ST_EN2]  = en_q.en_in;
    status[ST_INTR] = irq;
  end
endmodule

// File: rtl/bstrb_port.sv
module bstrb_port
  import bstrb_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic              inte1_we,
  input  logic              inte2_we,
  input  logic              inte_val,
  input  logic              cpu_wr_a,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_rd_a,
  input  logic              cpu_rd_st,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic [DATA_W-1:0] pa_in,
  output logic [DATA_W-1:0] pa_out,
  output logic              pa_oe,
  input  logic              stb_n,
  output logic              ibf,
  input  logic              ack_n,
  output logic              obf_n,
  output logic              intr
);
  logic              rst_core_n;
  logic              out_full;
  logic              in_full;
  logic [DATA_W-1:0] in_data;
  logic [ST_W-1:0]   status;

  bstrb_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  bstrb_out_path #(.W(DATA_W)) u_out (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .clr    (cfg_load),
    .wr     (cpu_wr_a),
    .wdata  (cpu_wdata),
    .ack_n  (ack_n),
    .out_q  (pa_out),
    .full_q (out_full)
  );

  bstrb_in_path #(.W(DATA_W)) u_in (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .clr    (cfg_load),
    .stb_n  (stb_n),
    .pin    (pa_in),
    .rd     (cpu_rd_a),
    .in_q   (in_data),
    .full_q (in_full)
  );

  bstrb_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .clr      (cfg_load),
    .inte1_we (inte1_we),
    .inte2_we (inte2_we),
    .inte_val (inte_val),
    .out_full (out_full),
    .in_full  (in_full),
    .irq      (intr),
    .status   (status)
  );

  always_comb begin
    cpu_rdata = '0;
    if (cpu_rd_st)     cpu_rdata[ST_W-1:0] = status;
    else if (cpu_rd_a) cpu_rdata = in_data;
  end

  assign pa_oe = ~ack_n;
  assign obf_n = ~out_full;
  assign ibf   = in_full;
endmodule

// File: rtl/bstrb_port_chk.sv
module bstrb_port_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_load,
  input logic              cpu_wr_a,
  input logic [DATA_W-1:0] cpu_wdata,
  input logic              cpu_rd_a,
  input logic [DATA_W-1:0] pa_out,
  input logic              stb_n,
  input logic              ack_n,
  input logic              obf_n,
  input logic              ibf,
  input logic              intr
);
  a_r2_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr_a && !cfg_load) |=> !obf_n);

  a_r2_write_data: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr_a && !cfg_load) |=> (pa_out == $past(cpu_wdata)));

  a_r4_ack_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_n && !cpu_wr_a && !cfg_load) |=> obf_n);

  a_r5_strobe_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb_n && !cfg_load) |=> ibf);

  a_r6_read_end_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cpu_rd_a) && stb_n) |=> !ibf);

  a_r10_load_idles: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> (obf_n && !ibf && !intr && (pa_out == '0)));

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!obf_n && !ibf) |-> !intr);
endmodule

bind bstrb_port bstrb_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .cfg_load  (cfg_load),
  .cpu_wr_a  (cpu_wr_a),
  .cpu_wdata (cpu_wdata),
  .cpu_rd_a  (cpu_rd_a),
  .pa_out    (pa_out),
  .stb_n     (stb_n),
  .ack_n     (ack_n),
  .obf_n     (obf_n),
  .ibf       (ibf),
  .intr      (intr)
);

// File: tb/bstrb_port_tb_top.sv
`timescale 1ns/1ps
module bstrb_port_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_load, inte1_we, inte2_we, inte_val;
  logic       cpu_wr_a, cpu_rd_a, cpu_rd_st;
  logic [7:0] cpu_wdata, pa_in;
  logic       stb_n, ack_n;
  logic [7:0] cpu_rdata, pa_out;
  logic       pa_oe, ibf, obf_n, intr;

  int    n_run  = 0;
  int    n_fail = 0;
  string phase  = "R1";

  // behavioural reference state
  bit       m_full_out, m_full_in, m_en1, m_en2, m_rd_prev;
  bit [7:0] m_out, m_in;

  always #2.5 clk = ~clk;

  bstrb_port dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .inte1_we(inte1_we),
    .inte2_we(inte2_we), .inte_val(inte_val), .cpu_wr_a(cpu_wr_a),
    .cpu_wdata(cpu_wdata), .cpu_rd_a(cpu_rd_a), .cpu_rd_st(cpu_rd_st),
    .cpu_rdata(cpu_rdata), .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .stb_n(stb_n), .ibf(ibf), .ack_n(ack_n), .obf_n(obf_n), .intr(intr)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_full_out = 0; m_full_in = 0; m_en1 = 0; m_en2 = 0;
      m_rd_prev = 0; m_out = 0; m_in = 0;
    end else begin
      if (cfg_load) begin
        m_full_out = 0; m_full_in = 0; m_en1 = 0; m_en2 = 0; m_out = 0;
      end else begin
        if (cpu_wr_a) begin m_out = cpu_wdata; m_full_out = 1; end
        else if (!ack_n) m_full_out = 0;
        if (!stb_n) begin m_in = pa_in; m_full_in = 1; end
        else if (m_rd_prev && !cpu_rd_a) m_full_in = 0;
        if (inte1_we) m_en1 = inte_val;
        if (inte2_we) m_en2 = inte_val;
      end
      m_rd_prev = cpu_rd_a;
    end
  end

  task automatic chk(string what, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", phase, what, act, exp);
    end
  endtask

  task automatic compare();
    bit       e_intr;
    bit [7:0] e_rd;
    e_intr = (m_en1 && !m_full_out) || (m_en2 && m_full_in);
    e_rd = 8'h00;
    if (cpu_rd_st) e_rd = {!m_full_out, m_en1, m_full_in, m_en2, e_intr, 3'b000};
    else if (cpu_rd_a) e_rd = m_in;
    chk("obf_n", {7'd0, obf_n}, {7'd0, !m_full_out});
    chk("ibf",   {7'd0, ibf},   {7'd0, m_full_in});
    chk("intr",  {7'd0, intr},  {7'd0, e_intr});
    chk("pa_oe", {7'd0, pa_oe}, {7'd0, !ack_n});
    chk("pa_out", pa_out, m_out);
    chk("cpu_rdata", cpu_rdata, e_rd);
  endtask

  task automatic cyc();
    @(negedge clk);
    compare();
  endtask

  task automatic idle();
    cfg_load = 0; inte1_we = 0; inte2_we = 0; inte_val = 0;
    cpu_wr_a = 0; cpu_rd_a = 0; cpu_rd_st = 0; cpu_wdata = 0;
    pa_in = 0; stb_n = 1; ack_n = 1;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    idle();
    rst_n = 0;
    // R1: reset state, checked during and after reset
    repeat (3) cyc();
    rst_n = 1;
    repeat (4) cyc();

    // R2 + R7: write, then read status (expect 0x00)
    phase = "R2";
    cpu_wr_a = 1; cpu_wdata = 8'hA5; cyc(); cpu_wr_a = 0;
    phase = "R7"; cpu_rd_st = 1; cyc(); cpu_rd_st = 0; cyc();

    // R9: enable output side; no request while full
    phase = "R9"; inte1_we = 1; inte_val = 1; cyc(); inte1_we = 0; cyc();
    // R3 + R4: acknowledge drives pins, empties; R8 request rises
    phase = "R3"; ack_n = 0; cyc(); cyc(); ack_n = 1; cyc();
    phase = "R8"; cpu_rd_st = 1; cyc(); cpu_rd_st = 0;   // status 0xC8
    cpu_wr_a = 1; cpu_wdata = 8'h5A; cyc(); cpu_wr_a = 0; cyc();

    // R4: write colliding with acknowledge keeps full
    phase = "R4"; ack_n = 0; cpu_wr_a = 1; cpu_wdata = 8'h11; cyc();
    cpu_wr_a = 0; ack_n = 1; cyc();

    // R5: strobe captures, latch holds afterwards
    phase = "R5"; pa_in = 8'h3C; stb_n = 0; cyc(); stb_n = 1; pa_in = 8'hFF; cyc();
    phase = "R9"; inte2_we = 1; inte_val = 1; cyc(); inte2_we = 0; cyc();
    // R6: read returns latch, clears after read end
    phase = "R6"; cpu_rd_a = 1; cyc(); cyc(); cpu_rd_a = 0; cyc(); cyc();
    // R6: strobe on the read-end cycle keeps ibf
    pa_in = 8'h77; stb_n = 0; cyc(); stb_n = 1; cpu_rd_a = 1; cyc();
    cpu_rd_a = 0; stb_n = 0; pa_in = 8'h78; cyc(); stb_n = 1; cyc();
    // R7: status over data when both selected
    phase = "R7"; cpu_rd_a = 1; cpu_rd_st = 1; cyc(); cpu_rd_a = 0; cpu_rd_st = 0; cyc();

    // R10: configuration load overrides a same-cycle write
    phase = "R10"; cfg_load = 1; cpu_wr_a = 1; cpu_wdata = 8'h99; cyc();
    cfg_load = 0; cpu_wr_a = 0; cyc();
    phase = "R11"; cyc();

    // mixed random traffic against the model
    phase = "R2/R4/R5/R6/R8 random";
    for (int i = 0; i < 2000; i++) begin
      cfg_load  = ($urandom_range(0, 63) == 0);
      inte1_we  = ($urandom_range(0, 7) == 0);
      inte2_we  = ($urandom_range(0, 7) == 0);
      inte_val  = $urandom_range(0, 1);
      cpu_wr_a  = ($urandom_range(0, 5) == 0);
      cpu_wdata = $urandom_range(0, 255);
      cpu_rd_a  = ($urandom_range(0, 3) == 0);
      cpu_rd_st = ($urandom_range(0, 5) == 0);
      pa_in     = $urandom_range(0, 255);
      stb_n     = ($urandom_range(0, 4) != 0);
      ack_n     = ($urandom_range(0, 4) != 0);
      cyc();
    end
    idle();
    cyc();

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule